// File: doc/BRIEF.md
# Line-Locked Carrier and PWM Comparator

This block derives a chopping carrier from the mains zero-crossing signal using counters only. It measures the line period in clock cycles between rising edges of the synchronized zero-crossing bit. It then spreads N carrier ticks evenly across the next period: each tick interval is the floor or the ceiling of the period divided by N, and there is no fixed divider. The first tick of every period falls on the line edge, so the carrier stays phase-aligned to the mains.

A digital sawtooth restarts at zero on every tick and then climbs by one per clock. A sequential divider computes the nominal tick interval, which sets the ramp's full scale. The duty word, a fraction of 2^DUTY_W, is scaled to that full scale to form a threshold. The PWM output is high while the ramp lies above the threshold, and the gate generator uses it for chopping.

A lock flag reports that successive line periods agree. It is cleared when the line period jumps or an edge goes missing.

Top module: `line_carrier`

## Requirements
- R1: While reset is asserted, tick, pwm and locked are low and ramp is zero.
- R2: Once a line period has been measured, tick is high in the cycle after each clock edge that first samples zc_sync high. The ramp is zero in that cycle.
- R3: Count c as clock edges after the edge that detected the rising edge of zc_sync, with the detecting edge itself as c = 0. Let P be the most recently measured period. Extra ticks appear at c = ceil(j·P/N) for j = 1..N-1, so a period of length P carries exactly N ticks. After the (N-1)-th extra tick, no further tick appears until the next rising edge.
- R4: The ramp is zero in every cycle in which tick is high. In every other cycle it is the previous value plus one, saturating at all ones.
- R5: The ramp threshold is floor(duty · floor(P/N) / 2^DUTY_W). It uses the period length captured at a rising edge, and takes effect at most PER_W+2 cycles after that edge.
- R6: pwm is high exactly when ramp is greater than the threshold. It is therefore never high while ramp is zero.
- R7: locked rises only in the cycle after a rising edge of zc_sync. It rises when the period just ended differs from the one before it by at most one clock, so the earliest lock follows the third rising edge.
- R8: At a rising edge, a period that differs from the previous one by more than LOCK_TOL clears locked. A difference from 2 to LOCK_TOL leaves locked unchanged.
- R9: While locked, if no rising edge arrives, locked stays high through c = P+LOCK_TOL and is low at c = P+LOCK_TOL+1.
- R10: The first rising edge after reset produces no tick, because no period is known yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_sync | input | 1 | Zero-crossing level, already synchronized; its rising edge marks the line reference |
| mult_n | input | N_W | Carrier multiple N (3 and up, not above the period in clocks) |
| duty | input | DUTY_W | Duty command as a fraction of 2^DUTY_W |
| tick | output | 1 | One-cycle carrier tick |
| ramp | output | PER_W | Sawtooth value |
| pwm | output | 1 | High while ramp exceeds the scaled duty |
| locked | output | 1 | Line period stable |

## Verification
The tick, the ramp restart and the lock flag all appear one cycle after the clock edge that first samples zc_sync high. The bench raises zc_sync half a cycle before edge c = 0 and reads the outputs one nanosecond after each edge. Every expected tick position is computed from c, P and N with the ceiling formula.

The threshold settles PER_W+2 cycles after an edge, so pwm and per-cycle tick checks run only in periods where both the period and the settings have already been steady for a full period. pwm is compared in the same cycle as the ramp sample it depends on.

The lock time-out is checked at c = P+LOCK_TOL and c = P+LOCK_TOL+1.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [0:0] {DIV_IDLE, DIV_RUN} div_state_e;
  typedef enum logic [1:0] {LK_HOLD, LK_SET, LK_CLEAR} lock_act_e;
endpackage

// File: rtl/lc_period_meter.sv
module lc_period_meter #(
  parameter int PER_W    = 24,
  parameter int LOCK_TOL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_i,
  output logic             start_o,
  output logic [PER_W-1:0] len_o,
  output logic [PER_W-1:0] period_o,
  output logic             locked_o
);
  import lc_pkg::*;

  localparam logic [PER_W-1:0] CNT_TOP = {{(PER_W-1){1'b1}}, 1'b0};
  localparam logic [PER_W:0]   TOL_EXT = (PER_W+1)'(LOCK_TOL);

  logic             zc_q, seen_q, have_q, lock_q;
  logic             seen_d, have_d, lock_d;
  logic [PER_W-1:0] cnt_q, cnt_d, per_q, per_d;
  logic [PER_W-1:0] cur_len, diff;
  logic [PER_W:0]   late_lim;
  logic             rise;
  lock_act_e        act;

  always_comb begin
    rise     = zc_i & ~zc_q;
    cur_len  = cnt_q + 1'b1;
    diff     = (cur_len >= per_q) ? (cur_len - per_q) : (per_q - cur_len);
    late_lim = {1'b0, per_q} + TOL_EXT;

    act = LK_HOLD;
    if (rise && have_q) begin
      if (diff <= PER_W'(1))               act = LK_SET;
      else if ({1'b0, diff} > TOL_EXT)     act = LK_CLEAR;
    end else if (have_q && ({1'b0, cur_len} > late_lim)) begin
      act = LK_CLEAR;
    end

    case (act)
      LK_SET:   lock_d = 1'b1;
      LK_CLEAR: lock_d = 1'b0;
      default:  lock_d = lock_q;
    endcase

    if (rise)                 cnt_d = '0;
    else if (cnt_q == CNT_TOP) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;

    seen_d = seen_q | rise;
    have_d = have_q | (rise & seen_q);
    per_d  = (rise && seen_q) ? cur_len : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q   <= 1'b0;
      seen_q <= 1'b0;
      have_q <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
    end else begin
      zc_q   <= zc_i;
      seen_q <= seen_d;
      have_q <= have_d;
      lock_q <= lock_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
    end
  end

  assign start_o  = rise & seen_q;
  assign len_o    = cur_len;
  assign period_o = per_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/lc_tick_gen.sv
module lc_tick_gen #(
  parameter int PER_W = 24,
  parameter int N_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [N_W-1:0]   mult_i,
  output logic             tick_o
);
  localparam int ACC_W = PER_W + 1;
  localparam int CNT_W = N_W + 1;

  logic             run_q, run_d;
  logic [ACC_W-1:0] acc_q, acc_d, sum, per_ext;
  logic [CNT_W-1:0] cnt_q, cnt_d, mult_ext;
  logic             hit, room, last;

  always_comb begin
    per_ext  = {1'b0, period_i};
    mult_ext = {1'b0, mult_i};
    sum      = acc_q + ACC_W'(mult_i);
    room     = (cnt_q + CNT_W'(1)) < mult_ext;
    last     = (cnt_q + CNT_W'(2)) >= mult_ext;
    hit      = run_q & room & (sum >= per_ext);
    tick_o   = start_i | hit;

    run_d = run_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (start_i) begin
      run_d = 1'b1;
      acc_d = '0;
      cnt_d = '0;
    end else if (run_q) begin
      if (!room) begin
        run_d = 1'b0;
      end else if (hit) begin
        acc_d = sum - per_ext;
        cnt_d = cnt_q + 1'b1;
        if (last) run_d = 1'b0;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lc_div.sv
module lc_div #(
  parameter int PER_W = 24,
  parameter int N_W   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PER_W-1:0] dividend_i,
  input  logic [N_W-1:0]   divisor_i,
  output logic [PER_W-1:0] quo_o,
  output logic             done_o
);
  import lc_pkg::*;

  localparam int STEP_W = $clog2(PER_W + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PER_W - 1);

  div_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [PER_W-1:0]  work_q, work_d, quo_q, quo_d, work_nx;
  logic [N_W-1:0]    rem_q, rem_d, dsr_q, dsr_d;
  logic [N_W:0]      rem_sh;
  logic              done_q, done_d, take;

  always_comb begin
    rem_sh  = {rem_q, work_q[PER_W-1]};
    take    = rem_sh >= {1'b0, dsr_q};
    work_nx = {work_q[PER_W-2:0], take};

    st_d   = st_q;
    step_d = step_q;
    work_d = work_q;
    rem_d  = rem_q;
    dsr_d  = dsr_q;
    quo_d  = quo_q;
    done_d = 1'b0;

    if (start_i) begin
      st_d   = DIV_RUN;
      step_d = '0;
      work_d = dividend_i;
      rem_d  = '0;
      dsr_d  = divisor_i;
    end else if (st_q == DIV_RUN) begin
      work_d = work_nx;
      rem_d  = N_W'(take ? (rem_sh - {1'b0, dsr_q}) : rem_sh);
      step_d = step_q + 1'b1;
      if (step_q == LAST) begin
        st_d   = DIV_IDLE;
        quo_d  = work_nx;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DIV_IDLE;
      step_q <= '0;
      work_q <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      quo_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      work_q <= work_d;
      rem_q  <= rem_d;
      dsr_q  <= dsr_d;
      quo_q  <= quo_d;
      done_q <= done_d;
    end
  end

  assign quo_o  = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/lc_ramp_cmp.sv
module lc_ramp_cmp #(
  parameter int PER_W  = 24,
  parameter int DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              span_ld_i,
  input  logic [PER_W-1:0]  span_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              tick_o,
  output logic [PER_W-1:0]  ramp_o,
  output logic              pwm_o
);
  localparam int PROD_W = PER_W + DUTY_W;
  localparam logic [PER_W-1:0] RAMP_MAX = '1;

  logic             tick_q;
  logic [PER_W-1:0] ramp_q, ramp_d, span_q, span_d, thr_q, thr_d;

  always_comb begin
    if (tick_i)                 ramp_d = '0;
    else if (ramp_q == RAMP_MAX) ramp_d = ramp_q;
    else                        ramp_d = ramp_q + 1'b1;

    span_d = span_ld_i ? span_i : span_q;
    thr_d  = PER_W'((PROD_W'(duty_i) * PROD_W'(span_q)) >> DUTY_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      ramp_q <= '0;
      span_q <= '0;
      thr_q  <= '0;
    end else begin
      tick_q <= tick_i;
      ramp_q <= ramp_d;
      span_q <= span_d;
      thr_q  <= thr_d;
    end
  end

  assign tick_o = tick_q;
  assign ramp_o = ramp_q;
  assign pwm_o  = ramp_q > thr_q;
endmodule

// File: rtl/line_carrier.sv
module line_carrier #(
  parameter int PER_W    = 24,
  parameter int N_W      = 14,
  parameter int DUTY_W   = 12,
  parameter int LOCK_TOL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc_sync,
  input  logic [N_W-1:0]    mult_n,
  input  logic [DUTY_W-1:0] duty,
  output logic              tick,
  output logic [PER_W-1:0]  ramp,
  output logic              pwm,
  output logic              locked
);
  logic             start_w, tick_w, span_ld_w;
  logic [PER_W-1:0] len_w, period_w, span_w;

  lc_period_meter #(.PER_W(PER_W), .LOCK_TOL(LOCK_TOL)) i_meter (
    .clk(clk), .rst_n(rst_n), .zc_i(zc_sync), .start_o(start_w),
    .len_o(len_w), .period_o(period_w), .locked_o(locked)
  );

  lc_tick_gen #(.PER_W(PER_W), .N_W(N_W)) i_ticks (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .period_i(period_w),
    .mult_i(mult_n), .tick_o(tick_w)
  );

  lc_div #(.PER_W(PER_W), .N_W(N_W)) i_div (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .dividend_i(len_w),
    .divisor_i(mult_n), .quo_o(span_w), .done_o(span_ld_w)
  );

  lc_ramp_cmp #(.PER_W(PER_W), .DUTY_W(DUTY_W)) i_ramp (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .span_ld_i(span_ld_w),
    .span_i(span_w), .duty_i(duty), .tick_o(tick), .ramp_o(ramp), .pwm_o(pwm)
  );
endmodule

// File: rtl/line_carrier_chk.sv
module line_carrier_chk #(
  parameter int PER_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             zc_sync,
  input logic             tick,
  input logic [PER_W-1:0] ramp,
  input logic             pwm,
  input logic             locked
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
  end

  // R4
  tick_ramp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (ramp == '0));

  // R4
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q != 2'd0) && !tick && ($past(ramp) != '1)) |-> (ramp == $past(ramp) + 1'b1));

  // R6
  pwm_needs_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |-> (ramp != '0));

  // R2
  edge_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q != 2'd0) && locked && zc_sync && !$past(zc_sync)) |=> tick);

  // R7
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q >= 2'd2) && $rose(locked)) |-> ($past(zc_sync) && !$past(zc_sync, 2)));
endmodule

bind line_carrier line_carrier_chk #(.PER_W(PER_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .zc_sync(zc_sync), .tick(tick),
  .ramp(ramp), .pwm(pwm), .locked(locked)
);

// File: tb/test_line_carrier.sv
`timescale 1ns/1ps
module test_line_carrier;
  localparam int PER_W = 12;
  localparam int N_W = 8;
  localparam int DUTY_W = 8;
  localparam int TOL = 4;

  logic clk, rst_n, zc_sync, tick, pwm, locked;
  logic [N_W-1:0] mult_n;
  logic [DUTY_W-1:0] duty;
  logic [PER_W-1:0] ramp;

  int n_checks, n_fails, prev_ramp;
  bit done_flag;

  line_carrier #(.PER_W(PER_W), .N_W(N_W), .DUTY_W(DUTY_W), .LOCK_TOL(TOL)) i_line_carrier (
    .clk(clk), .rst_n(rst_n), .zc_sync(zc_sync), .mult_n(mult_n), .duty(duty),
    .tick(tick), .ramp(ramp), .pwm(pwm), .locked(locked));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_tick(input int c, input int p, input int n);
    if (c == 0) return 1'b1;
    if (c >= p) return 1'b0;
    return ((c * n) / p) > (((c - 1) * n) / p);
  endfunction

  // One line period of length p; pprev is the period measured at its start edge.
  task automatic run_period(input int p, input int pprev, input bit full, input int lock_exp, input int tick0_exp);
    int nt = 0;
    int thr = (int'(duty) * (pprev / int'(mult_n))) >> DUTY_W;
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      zc_sync = (c < p / 2);
      @(posedge clk);
      #1;
      if (c == 0 && tick0_exp >= 0) check(tick == tick0_exp[0], "R2/R10 tick at edge", tick, tick0_exp);
      if (c == 0 && lock_exp >= 0) check(locked == lock_exp[0], "R7/R8 locked at edge", locked, lock_exp);
      if (full) begin
        check(tick == exp_tick(c, pprev, mult_n), "R3 tick position", tick, exp_tick(c, pprev, mult_n));
        if (tick) check(ramp == 0, "R4 ramp restart", ramp, 0);
        else check(int'(ramp) == prev_ramp + 1, "R4 ramp step", ramp, prev_ramp + 1);
        check(pwm == (int'(ramp) > thr), "R5/R6 pwm vs threshold", pwm, int'(int'(ramp) > thr));
      end
      if (tick) nt++;
      prev_ramp = ramp;
    end
    if (full) check(nt == int'(mult_n), "R3 ticks per period", nt, mult_n);
  endtask

  task automatic run_silent(input int p);
    for (int c = 0; c <= p + TOL + 4; c++) begin
      @(negedge clk);
      zc_sync = (c < p / 2);
      @(posedge clk);
      #1;
      if (c == p + TOL) check(locked == 1'b1, "R9 lock held to limit", locked, 1);
      if (c == p + TOL + 1) check(locked == 1'b0, "R9 lock dropped after limit", locked, 0);
      if (c >= p) check(tick == 1'b0, "R3 no tick past N", tick, 0);
      prev_ramp = ramp;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #750000;
    n_fails++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    finish_run();
  end

  initial begin
    int plist[4] = '{60, 61, 97, 128};
    int nlist[4] = '{3, 5, 7, 16};
    int dlist[3] = '{0, 100, 255};
    n_checks = 0; n_fails = 0; prev_ramp = 0; done_flag = 1'b0;
    rst_n = 1'b0; zc_sync = 1'b0; mult_n = 5; duty = 0;
    repeat (3) @(posedge clk);
    #1;
    check(tick == 0 && pwm == 0 && locked == 0, "R1 reset outputs low", {tick, pwm, locked}, 0);
    check(ramp == 0, "R1 reset ramp", ramp, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // lock sequence: period lengths 80,80,80,83,83,90,90,90
    run_period(80, 0, 0, 0, 0);   // R10: first edge, no tick
    run_period(80, 80, 0, 0, 1);
    run_period(80, 80, 0, 1, 1);  // R7
    run_period(83, 80, 0, 1, 1);
    run_period(83, 83, 0, 1, 1);  // R8: diff 3 holds
    run_period(90, 83, 0, 1, 1);
    run_period(90, 90, 0, 0, 1);  // R8: diff 7 clears
    run_period(90, 90, 0, 1, 1);  // R7 relock
    run_silent(90);               // R9

    for (int pi = 0; pi < 4; pi++)
      for (int ni = 0; ni < 4; ni++)
        for (int di = 0; di < 3; di++) begin
          mult_n = N_W'(nlist[ni]);
          duty = DUTY_W'(dlist[di]);
          run_period(plist[pi], plist[pi], 0, -1, -1);
          run_period(plist[pi], plist[pi], 0, -1, -1);
          run_period(plist[pi], plist[pi], 1, -1, -1);
          run_period(plist[pi], plist[pi], 1, -1, -1);
        end
    finish_run();
  end
endmodule